// File: doc/BRIEF.md
# Programmable Clock Burst Generator

This block drives a synchronous device under test with three derived clocks for a counted run, then stops. Each derived clock is produced from a fast reference clock. It has its own period, high time and phase offset, all counted in reference cycles. A burst length sets how many clock-0 periods one run produces. A cycles-per-sample divider marks the clock-0 edges on which the test side exchanges meaningful data.

A host loads the parameters through a single-cycle write port while the block is idle. It then pulses `start` and waits for the one-cycle `done` pulse. While `busy` is high, the stimulus pin register and the response capture register are both frozen. Parameter writes and further start pulses are dropped. Between bursts every derived clock rests low.

Top module: `burst_clk_gen`

## Requirements
- R1: While busy, successive rising edges of derived clock k are exactly Pk reference cycles apart. Pk is the written period, or 2 when the written period is below 2.
- R2: Each full high pulse of clock k lasts (written high time mod Pk) reference cycles. A high time of zero keeps that clock low.
- R3: With phase value F = (written phase mod Pk) and high time H, the first cycle of a burst is index 0 (the first cycle in which busy reads 1). The first high level of clock k appears at index 1 when F < H, and otherwise at index 1+Pk−F.
- R4: A burst of length L (24-bit field) yields exactly L rising edges of clock 0 that start a full period. A leading partial pulse caused by a phase below the high time is not counted. Busy stays high for ((P0−F0) mod P0) + L·P0 + 1 cycles.
- R5: A start with L = 0 raises done in the next cycle, never raises busy and produces no clock edge.
- R6: Done is a single pulse in the first cycle after busy falls. All derived clocks read 0 whenever busy is low.
- R7: sampleStb is high together with every Nth counted rising edge of clock 0 during a burst. A burst therefore gives floor(L/N) strobes. A written N of 0 acts as 1.
- R8: Register writes and start pulses that arrive while busy is high have no effect.
- R9: stimPins takes the value written at address 2 in the cycle after an idle write. It holds its value for the whole burst.
- R10: When idle, respCapt copies respPins with one cycle of delay. While busy, it holds the last value captured.
- R11: Register addresses are as follows. Address 0 holds the burst length in wrData[23:0]. Address 1 holds N in wrData[7:0]. Address 2 holds the stimulus value in wrData[7:0]. Address 4+k holds clock k's settings: period in wrData[7:0], high time in [15:8] and phase in [23:16]. Reset values are length 0, N 1, period 2, high time 1, phase 0 and stimulus 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| start | input | 1 | Begin a burst (single-cycle pulse) |
| respPins | input | 8 | Response pins from the device |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| dutClk | output | 3 | Derived clocks to the device |
| sampleStb | output | 1 | Marks every Nth clock-0 edge |
| stimPins | output | 8 | Stimulus pin register |
| respCapt | output | 8 | Captured response pins |

## Verification
A start sampled at a rising edge raises busy in the next cycle. The derived clocks are one register further on: a counter value present in burst cycle i shows on the pins in cycle i+1. The final counted period ends when done appears, one cycle after the last busy cycle. The monitor samples on the falling edge. It indexes every clock edge from the first busy cycle and compares each edge against the expected index, period and high width. When done appears, it pops an expected item (edge count, strobe count, busy length) queued by the driver when the start was issued. Register and capture effects are read one full cycle after the write, or after the done cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef struct packed {
    logic load;    // idle start with nonzero length: preset counters
    logic run;     // burst active
    logic finish;  // terminating period start, force clocks low
  } ctrl_strobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  localparam int ADDR_LEN  = 0;
  localparam int ADDR_SPS  = 1;
  localparam int ADDR_STIM = 2;
  localparam int ADDR_CLK0 = 4;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int SPS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             event0,
  input  logic [LEN_W-1:0] lenReg,
  input  logic [SPS_W-1:0] spsReg,
  output ctrl_strobe_t     strb,
  output logic             busy,
  output logic             done,
  output logic             sampleStb
);
  state_t           state;
  logic [LEN_W-1:0] remaining;
  logic [SPS_W-1:0] spsCnt;
  logic [SPS_W-1:0] spsEff;

  assign spsEff = (spsReg == '0) ? SPS_W'(1) : spsReg;
  assign busy   = (state == ST_RUN);

  always_comb begin
    strb.load   = (state == ST_IDLE) && start && (lenReg != '0);
    strb.run    = (state == ST_RUN);
    strb.finish = (state == ST_RUN) && event0 && (remaining == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      spsCnt    <= '0;
      done      <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      done      <= 1'b0;
      sampleStb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (lenReg == '0) begin
              done <= 1'b1;
            end else begin
              state     <= ST_RUN;
              remaining <= lenReg;
              spsCnt    <= '0;
            end
          end
        end
        ST_RUN: begin
          if (event0) begin
            if (remaining == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              remaining <= remaining - 1'b1;
              if (spsCnt == spsEff - 1'b1) begin
                sampleStb <= 1'b1;
                spsCnt    <= '0;
              end else begin
                spsCnt <= spsCnt + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_fall_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_strobe_in_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> busy);
  p_finish_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busy);
endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int NUM_CLK = 3,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 24,
  parameter int SPS_W   = 8,
  parameter int PIN_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PIN_W-1:0]  respPins,
  output logic [LEN_W-1:0]  lenReg,
  output logic [SPS_W-1:0]  spsReg,
  output logic              event0,
  output logic [NUM_CLK-1:0] dutClk,
  output logic [PIN_W-1:0]  stimPins,
  output logic [PIN_W-1:0]  respCapt
);
  logic              wrOk;
  logic [NUM_CLK-1:0] atZero;

  assign wrOk   = wrEn && !busy;
  assign event0 = strb.run && atZero[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg   <= '0;
      spsReg   <= SPS_W'(1);
      stimPins <= '0;
      respCapt <= '0;
    end else begin
      if (wrOk && wrAddr == ADDR_W'(ADDR_LEN))  lenReg   <= wrData[LEN_W-1:0];
      if (wrOk && wrAddr == ADDR_W'(ADDR_SPS))  spsReg   <= wrData[SPS_W-1:0];
      if (wrOk && wrAddr == ADDR_W'(ADDR_STIM)) stimPins <= wrData[PIN_W-1:0];
      if (!busy) respCapt <= respPins;
    end
  end

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
    logic [DIV_W-1:0] perReg, highReg, phaseReg;
    logic [DIV_W-1:0] perEff, highMod, phaseMod, cnt;
    logic             clkQ, wrThis;

    assign wrThis   = wrOk && (wrAddr == ADDR_W'(ADDR_CLK0 + k));
    assign perEff   = (perReg < DIV_W'(2)) ? DIV_W'(2) : perReg;
    assign highMod  = highReg % perEff;
    assign phaseMod = phaseReg % perEff;
    assign atZero[k] = (cnt == '0);
    assign dutClk[k] = clkQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        perReg   <= DIV_W'(2);
        highReg  <= DIV_W'(1);
        phaseReg <= '0;
        cnt      <= '0;
        clkQ     <= 1'b0;
      end else begin
        if (wrThis) begin
          perReg   <= wrData[0*DIV_W +: DIV_W];
          highReg  <= wrData[1*DIV_W +: DIV_W];
          phaseReg <= wrData[2*DIV_W +: DIV_W];
        end
        if (strb.load)
          cnt <= phaseMod;
        else if (strb.run)
          cnt <= (cnt == perEff - 1'b1) ? '0 : cnt + 1'b1;
        clkQ <= strb.run && !strb.finish && (cnt < highMod);
      end
    end
  end

  p_idle_clocks_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (dutClk == '0));
  p_stim_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(stimPins));
  p_capture_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(respCapt));
  p_len_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lenReg));
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import bcg_pkg::*;
#(
  parameter int NUM_CLK = 3,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 24,
  parameter int SPS_W   = 8,
  parameter int PIN_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               start,
  input  logic [PIN_W-1:0]   respPins,
  output logic               busy,
  output logic               done,
  output logic [NUM_CLK-1:0] dutClk,
  output logic               sampleStb,
  output logic [PIN_W-1:0]   stimPins,
  output logic [PIN_W-1:0]   respCapt
);
  ctrl_strobe_t     strb;
  logic             event0;
  logic [LEN_W-1:0] lenReg;
  logic [SPS_W-1:0] spsReg;

  bcg_ctrl #(.LEN_W(LEN_W), .SPS_W(SPS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .event0(event0),
    .lenReg(lenReg), .spsReg(spsReg), .strb(strb),
    .busy(busy), .done(done), .sampleStb(sampleStb)
  );

  bcg_datapath #(
    .NUM_CLK(NUM_CLK), .DIV_W(DIV_W), .LEN_W(LEN_W), .SPS_W(SPS_W),
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .respPins(respPins),
    .lenReg(lenReg), .spsReg(spsReg), .event0(event0),
    .dutClk(dutClk), .stimPins(stimPins), .respCapt(respCapt)
  );
endmodule

// File: tb/burst_clk_gen_tb.sv
`timescale 1ns/1ps
module burst_clk_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        start = 1'b0;
  logic [7:0]  respPins = '0;
  logic        busy, done, sampleStb;
  logic [2:0]  dutClk;
  logic [7:0]  stimPins, respCapt;

  always #2 clk = ~clk;

  burst_clk_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .respPins(respPins), .busy(busy), .done(done),
    .dutClk(dutClk), .sampleStb(sampleStb), .stimPins(stimPins),
    .respCapt(respCapt)
  );

  typedef struct { int edges; int strobes; int busyCyc; } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  int pE[3], hM[3], phM[3];
  int cfgLen = 0, cfgN = 1;
  int idx = 0, busyCnt = 0, riseCnt0 = 0, strobeCnt = 0, doneCnt = 0;
  int lastRise[3];
  bit seenRise[3];
  bit prevBusy = 0;
  logic [2:0] prevLvl = '0;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 32'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setClk(int k, int p, int h, int ph);
    int pe;
    writeReg(4 + k, (ph << 16) | (h << 8) | p);
    pe = (p < 2) ? 2 : p;
    pE[k] = pe; hM[k] = h % pe; phM[k] = ph % pe;
  endtask

  task automatic setLen(int v); writeReg(0, v); cfgLen = v; endtask
  task automatic setN(int v);   writeReg(1, v); cfgN = v;   endtask

  // driver: queue the expected outcome, then pulse start
  task automatic startBurst();
    exp_t e;
    int nEff, d0;
    nEff = (cfgN == 0) ? 1 : cfgN;
    d0 = (pE[0] - phM[0]) % pE[0];
    e.edges = cfgLen;
    e.strobes = cfgLen / nEff;
    e.busyCyc = (cfgLen == 0) ? 0 : d0 + cfgLen * pE[0] + 1;
    expQ.push_back(e);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(int base);
    while (doneCnt == base) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rstN) begin
      prevBusy = 0; prevLvl = '0;
    end else begin
      if (busy) begin
        if (!prevBusy) begin
          idx = 0; busyCnt = 0; riseCnt0 = 0; strobeCnt = 0;
          for (int k = 0; k < 3; k++) begin lastRise[k] = -1000; seenRise[k] = 0; end
        end else idx++;
        busyCnt++;
      end
      for (int k = 0; k < 3; k++) begin
        if (dutClk[k] && !prevLvl[k]) begin
          if (!busy) check(0, "R6", 1, 0);
          else if (!seenRise[k]) begin
            int expIdx;
            bit partial;
            partial = (phM[k] < hM[k]) && (phM[k] != 0);
            expIdx = (phM[k] < hM[k]) ? 1 : 1 + pE[k] - phM[k];
            check(idx == expIdx, "R3", idx, expIdx);
            lastRise[k] = (phM[k] < hM[k]) ? 1 - phM[k] : idx;
            seenRise[k] = 1;
            if (k == 0 && !partial) riseCnt0++;
          end else begin
            check(idx - lastRise[k] == pE[k], "R1", idx - lastRise[k], pE[k]);
            lastRise[k] = idx;
            if (k == 0) riseCnt0++;
          end
        end
        if (!dutClk[k] && prevLvl[k] && busy)
          check(idx - lastRise[k] == hM[k], "R2", idx - lastRise[k], hM[k]);
      end
      if (sampleStb) begin
        strobeCnt++;
        check(dutClk[0] && !prevLvl[0], "R7", int'(dutClk[0]), 1);
      end
      if (done) begin
        doneCnt++;
        check(!busy && dutClk == '0, "R6", int'({busy, dutClk}), 0);
        if (expQ.size() == 0) check(0, "R8", doneCnt, doneCnt - 1);
        else begin
          exp_t e;
          e = expQ.pop_front();
          check(riseCnt0 == e.edges, "R4", riseCnt0, e.edges);
          check(strobeCnt == e.strobes, "R7", strobeCnt, e.strobes);
          check(busyCnt == e.busyCyc, (e.edges == 0) ? "R5" : "R4", busyCnt, e.busyCyc);
        end
        busyCnt = 0; riseCnt0 = 0; strobeCnt = 0;
      end
      prevBusy = busy;
      prevLvl = dutClk;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R4 watchdog", 190000, 0);
    finishRun();
  end

  initial begin
    int base;
    for (int k = 0; k < 3; k++) begin pE[k] = 2; hM[k] = 1; phM[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R11, R6)
    check(busy == 0 && done == 0 && sampleStb == 0, "R11", int'({busy, done, sampleStb}), 0);
    check(dutClk == 0, "R6", int'(dutClk), 0);
    check(stimPins == 0, "R11", int'(stimPins), 0);

    // stimulus write while idle (R9)
    writeReg(2, 'h5A);
    check(stimPins == 8'h5A, "R9", int'(stimPins), 'h5A);

    // burst A: mixed periods and phases (R1 R2 R3 R4 R7)
    setClk(0, 4, 2, 0); setClk(1, 6, 3, 2); setClk(2, 5, 1, 4);
    setN(2); setLen(5);
    base = doneCnt; startBurst(); waitDone(base);

    // zero length (R5)
    setLen(0);
    base = doneCnt; startBurst(); waitDone(base);
    check(doneCnt == base + 1, "R5", doneCnt - base, 1);

    // modulo and minimum period, N of 0 (R2 R3 R7)
    setClk(0, 1, 7, 3); setClk(1, 4, 6, 9);
    setN(0); setLen(4);
    base = doneCnt; startBurst(); waitDone(base);

    // locks during a burst (R8 R9 R10)
    setClk(0, 3, 1, 0); setN(3); setLen(6);
    respPins = 8'h3C;
    repeat (2) @(negedge clk);
    check(respCapt == 8'h3C, "R10", int'(respCapt), 'h3C);
    base = doneCnt; startBurst();
    respPins = 8'hC3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    writeReg(2, 'hAA);
    check(stimPins == 8'h5A, "R9", int'(stimPins), 'h5A);
    writeReg(0, 9);
    writeReg(4, 7);
    check(respCapt == 8'h3C, "R10", int'(respCapt), 'h3C);
    waitDone(base);
    check(stimPins == 8'h5A, "R8", int'(stimPins), 'h5A);
    check(respCapt == 8'hC3, "R10", int'(respCapt), 'hC3);
    // repeat with the mirror: dropped writes must not show (R8)
    base = doneCnt; startBurst(); waitDone(base);

    // length above 16 bits (R4)
    setClk(0, 2, 1, 0); setN(4); setLen('h10001);
    base = doneCnt; startBurst(); waitDone(base);
    check(expQ.size() == 0, "R4", expQ.size(), 0);

    finishRun();
  end
endmodule